// File: doc/BRIEF.md
# Serial Line-Code Transmitter

This block serialises bytes into a single line-coded waveform. A writer hands bytes over through a one-byte holding register with a valid/ready handshake. The block moves each byte into an 8-bit shift register and sends it most significant bit first. Each bit is encoded as pulse-width code, Manchester code or biphase code. A two-bit select input chooses the code, and the block samples it at every byte load.

A programmable prescaler sets the bit rate and also paces the shift register. Every bit period is six phase steps long, and each phase step lasts `bit_div + 1` clock cycles. Six steps allow both the thirds of the pulse-width code and the halves of the other two codes. While the writer keeps the holding register filled, bytes follow one another with no gap. If the holding register is empty when a byte ends, the line falls to idle low.

Top module: `linecode_tx`

## Requirements
- R1: After reset, `tx_out` is 0, `busy` is 0 and `wr_ready` is 1.
- R2: A byte is sent MSB first. The coded level of its first bit is on `tx_out` in the cycle after the load edge, which is the same cycle in which `busy` rises.
- R3: Each bit lasts six phase steps of `bit_div + 1` clock cycles each. A lone byte keeps `busy` high for exactly 48*(`bit_div`+1) cycles.
- R4: Pulse-width code (`code_sel` 0, and also 3): a 1 is high for phase steps 0-3 and low for steps 4-5. A 0 is high for steps 0-1 and low for steps 2-5.
- R5: Manchester code (`code_sel` 1): a 1 is high for steps 0-2 and low for steps 3-5. A 0 is low for steps 0-2 and high for steps 3-5.
- R6: Biphase code (`code_sel` 2): the level inverts at the start of every bit. The first bit after idle starts high. A 0 adds a second inversion at step 3, and a 1 holds its level for the whole bit.
- R7: `wr_ready` is high whenever the holding register is empty or is being emptied in the same cycle. A byte written while another byte is being sent follows it with `busy` held high and no gap.
- R8: If the holding register is empty when the last bit of a byte ends, `busy` and `tx_out` are both 0 in the next cycle.
- R9: The block latches `code_sel` when a byte loads. A change of `code_sel` in the middle of a byte has no effect on that byte.
- R10: While `enable` is low, no byte starts. A byte already being sent runs to its end, and a stored byte waits with `wr_ready` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Allows new bytes to start |
| code_sel | input | 2 | 0/3 pulse-width, 1 Manchester, 2 biphase |
| bit_div | input | DIV_W | Phase step length minus one, in clocks |
| wr_valid | input | 1 | Write request for the holding register |
| wr_data | input | DATA_W | Byte to send |
| wr_ready | output | 1 | Holding register can take a byte |
| tx_out | output | 1 | Line-coded output |
| busy | output | 1 | A byte is being sent |

## Verification
The important collision is a byte load from the holding register on the same edge as a new write into that register. On that edge `wr_ready` stays high because the register is being drained. The bench provokes this by raising `wr_valid` with the next byte as soon as `wr_ready` allows, so the write falls on the load edge of each previous byte. The bench judges the result by decoding the waveform at the start of every phase step. Every byte must come back intact and in order, `busy` must never drop between bytes, and the line must fall to idle exactly one byte length after the last load.

// File: rtl/lc_pkg.sv
// Shared types and constants of the line-code transmitter.
package lc_pkg;
    typedef enum logic [1:0] {
        CODE_PWM  = 2'd0,
        CODE_MAN  = 2'd1,
        CODE_BIP  = 2'd2,
        CODE_PWM2 = 2'd3
    } code_e;

    localparam int PHASES = 6;   // phase steps per bit
    localparam int PH_W   = 3;   // width of the phase counter
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);
    localparam logic [PH_W-1:0] PH_HALF = PH_W'(PHASES / 2);
endpackage

// File: rtl/lc_prescaler.sv
// Phase-step prescaler.
// Emits a one-cycle tick every bit_div+1 cycles while run is high.
// Assumes: the count restarts at zero whenever run is low, so the first step
// after a start is a full one.
module lc_prescaler #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    // Count clock cycles inside the current phase step.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3: after a tick the step count restarts from zero
    a_r3_tick_restart: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == '0));
endmodule

// File: rtl/lc_holdreg.sv
// One-byte holding register between the writer and the shift register.
// Accepts a write on the same edge on which the shifter takes the byte it
// holds.
// Assumes: take is only raised while full is high.
module lc_holdreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              wr_ready,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    logic fire;

    assign wr_ready = !full || take;
    assign fire     = wr_valid && wr_ready;

    // Store an incoming byte, or clear the full flag when the byte is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (fire) begin
            full <= 1'b1;
            data <= wr_data;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    // R7: an accepted write always leaves the register full
    a_r7_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> full);
    // R7: a byte is never taken from an empty register
    a_r7_take_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> full);
endmodule

// File: rtl/lc_shifter.sv
// Byte shift register with bit and phase counters.
// Loads from the holding register when idle, or at the last tick of a byte
// (chaining). Shifts left by one bit at the end of each bit. The code select
// is latched with every load.
// Assumes: tick only pulses while active is high.
module lc_shifter #(
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable,
    input  logic                    tick,
    input  logic                    hold_full,
    input  logic [DATA_W-1:0]       hold_data,
    input  logic [1:0]              code_sel,
    output logic                    active,
    output logic                    cur_bit,
    output logic [lc_pkg::PH_W-1:0] phase,
    output lc_pkg::code_e           code_q,
    output logic                    take,
    output logic                    start,
    output logic                    bit_adv
);
    import lc_pkg::*;

    localparam int BC_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [BC_W-1:0] BC_LAST = BC_W'(DATA_W - 1);

    logic [DATA_W-1:0] sr;
    logic [BC_W-1:0]   bit_cnt;
    logic              bit_end;
    logic              byte_end;
    logic              chain;

    assign cur_bit  = sr[DATA_W-1];
    assign bit_end  = active && tick && (phase == PH_LAST);
    assign byte_end = bit_end && (bit_cnt == BC_LAST);
    assign start    = !active && hold_full && enable;
    assign chain    = byte_end && hold_full && enable;
    assign take     = start || chain;
    assign bit_adv  = bit_end;

    // Sequence loads, phase steps, bit shifts and the stop at a starved end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            sr      <= '0;
            bit_cnt <= '0;
            phase   <= '0;
            code_q  <= CODE_PWM;
        end else if (take) begin
            active  <= 1'b1;
            sr      <= hold_data;
            bit_cnt <= '0;
            phase   <= '0;
            code_q  <= code_e'(code_sel);
        end else if (byte_end) begin
            active  <= 1'b0;
            bit_cnt <= '0;
            phase   <= '0;
        end else if (tick) begin
            if (phase == PH_LAST) begin
                phase   <= '0;
                bit_cnt <= bit_cnt + 1'b1;
                sr      <= {sr[DATA_W-2:0], 1'b0};
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

    // R8: a byte that ends with nothing stored leaves the block idle
    a_r8_starve_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_end && !hold_full) |=> !active);
    // R10: with enable low an idle block never starts
    a_r10_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !enable) |=> !active);
    // R9: the latched code only changes on a load
    a_r9_code_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(code_q));
    // R3: the phase does not move between ticks
    a_r3_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !tick && !take) |=> $stable(phase));
endmodule

// File: rtl/lc_encoder.sv
// Line-code encoder.
// Maps the current bit and phase step to an output level for the latched
// code. Keeps the biphase start level in a register.
// Assumes: idle level is low, so the first biphase bit after idle starts high.
module lc_encoder (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    active,
    input  logic                    cur_bit,
    input  logic [lc_pkg::PH_W-1:0] phase,
    input  lc_pkg::code_e           code_q,
    input  logic                    start,
    input  logic                    bit_adv,
    output logic                    tx_out
);
    import lc_pkg::*;

    logic bp_lvl;   // biphase level in the first half of the current bit

    // Track the biphase level from bit to bit: invert after a 1, keep after a 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bp_lvl <= 1'b0;
        end else if (start) begin
            bp_lvl <= 1'b1;
        end else if (bit_adv) begin
            bp_lvl <= cur_bit ? ~bp_lvl : bp_lvl;
        end
    end

    // Choose the output level for this code, bit and phase step.
    always_comb begin
        if (!active) begin
            tx_out = 1'b0;
        end else begin
            case (code_q)
                CODE_MAN: tx_out = cur_bit ? (phase < PH_HALF) : (phase >= PH_HALF);
                CODE_BIP: tx_out = (phase < PH_HALF || cur_bit) ? bp_lvl : ~bp_lvl;
                default:  tx_out = cur_bit ? (phase < PH_W'(4)) : (phase < PH_W'(2));
            endcase
        end
    end
endmodule

// File: rtl/linecode_tx.sv
// Top of the serial line-code transmitter.
// Joins the holding register, prescaler, shifter and encoder.
// Assumes: one clock domain, with bit_div held steady while a byte is sent.
module linecode_tx #(
    parameter int DIV_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [1:0]        code_sel,
    input  logic [DIV_W-1:0]  bit_div,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              tx_out,
    output logic              busy
);
    import lc_pkg::*;

    logic              tick;
    logic              take;
    logic              start;
    logic              bit_adv;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              active;
    logic              cur_bit;
    logic [PH_W-1:0]   phase;
    code_e             code_q;

    assign busy = active;

    lc_holdreg #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .take(take), .wr_ready(wr_ready), .full(hold_full), .data(hold_data)
    );

    lc_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(active), .div(bit_div), .tick(tick)
    );

    lc_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
        .hold_full(hold_full), .hold_data(hold_data), .code_sel(code_sel),
        .active(active), .cur_bit(cur_bit), .phase(phase), .code_q(code_q),
        .take(take), .start(start), .bit_adv(bit_adv)
    );

    lc_encoder u_enc (
        .clk(clk), .rst_n(rst_n), .active(active), .cur_bit(cur_bit),
        .phase(phase), .code_q(code_q), .start(start), .bit_adv(bit_adv),
        .tx_out(tx_out)
    );

    // R5: Manchester always has a transition at mid-bit
    a_r5_man_midbit: assert property (@(posedge clk) disable iff (!rst_n)
        (active && code_q == CODE_MAN && tick && phase == PH_W'(2) && !take)
        |=> (tx_out != $past(tx_out)));
    // R6: biphase inverts at every bit boundary inside a byte
    a_r6_bip_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (active && code_q == CODE_BIP && bit_adv && !take && busy)
        |=> (!busy || tx_out != $past(tx_out)));
    // R8: the line is low whenever no byte is being sent
    a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !tx_out);
    // R2: a start from idle drives the first bit's level at once
    a_r2_first_level: assert property (@(posedge clk) disable iff (!rst_n)
        (start && code_q != CODE_MAN && code_sel != 2'd1) |=> tx_out);
endmodule

// File: tb/linecode_tx_test.sv
module linecode_tx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [1:0] code_sel = 2'd0;
    logic [7:0] bit_div = 8'd0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       wr_ready;
    logic       tx_out;
    logic       busy;

    int checks = 0;
    int errors = 0;
    logic [7:0] tx_bytes [0:7];

    always #4 clk = ~clk;   // 125 MHz

    linecode_tx uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .code_sel(code_sel),
        .bit_div(bit_div), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .tx_out(tx_out), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Hand one byte over; called and returning at a falling edge.
    task automatic write_byte(input logic [7:0] d);
        wr_valid = 1'b1;
        wr_data  = d;
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    // Level expected from the requirements for code c, bit b, phase k.
    function automatic logic exp_level(input logic [1:0] c, input logic b,
                                       input int k, input logic bp_first);
        case (c)
            2'd1:    return b ? (k < 3) : (k >= 3);
            2'd2:    return (k < 3 || b) ? bp_first : ~bp_first;
            default: return b ? (k < 4) : (k < 2);
        endcase
    endfunction

    // Sample each phase step of n bytes, decode them and compare.
    task automatic decode(input logic [1:0] c, input int p, input int n, input string req);
        logic prev_end = 1'b0;
        while (!busy) @(negedge clk);
        for (int b = 0; b < n; b++) begin
            int bad = 0;
            logic [7:0] rx = 8'd0;
            for (int i = 7; i >= 0; i--) begin
                logic s [0:5];
                logic bitv = tx_bytes[b][i];
                logic first = ~prev_end;
                for (int k = 0; k < 6; k++) begin
                    logic e = exp_level(c, bitv, k, first);
                    s[k] = tx_out;
                    if (s[k] !== e || busy !== 1'b1) bad++;
                    if (b == 0 && i == 7 && k == 0)
                        check(s[k] === e && busy === 1'b1, "R2", "first level",
                              int'(s[k]), int'(e));
                    repeat (p) @(negedge clk);
                end
                case (c)
                    2'd1:    rx[i] = s[0];
                    2'd2:    rx[i] = (s[0] == s[3]);
                    default: rx[i] = s[2];
                endcase
                prev_end = exp_level(c, bitv, 5, first);
            end
            check(rx == tx_bytes[b], req, "decoded byte", rx, tx_bytes[b]);
            check(bad == 0, req, "waveform/continuity mismatches (R7)", bad, 0);
        end
        check(busy === 1'b0 && tx_out === 1'b0, "R8", "idle after last byte",
              int'({busy, tx_out}), 0);
    endtask

    task automatic run_stream(input logic [1:0] c, input int div, input int n,
                              input string req);
        code_sel = c;
        bit_div  = 8'(div);
        enable   = 1'b1;
        fork
            begin
                for (int i = 0; i < n; i++) write_byte(tx_bytes[i]);
            end
            decode(c, div + 1, n, req);
        join
    endtask

    task automatic t_reset;
        check(tx_out === 1'b0, "R1", "tx_out after reset", int'(tx_out), 0);
        check(busy === 1'b0, "R1", "busy after reset", int'(busy), 0);
        check(wr_ready === 1'b1, "R1", "wr_ready after reset", int'(wr_ready), 1);
    endtask

    task automatic t_pwm;
        tx_bytes[0] = 8'hB4; tx_bytes[1] = 8'h49; tx_bytes[2] = 8'h9B;
        run_stream(2'd0, 0, 3, "R4");
    endtask

    task automatic t_pwm_alt;
        tx_bytes[0] = 8'h5A;
        run_stream(2'd3, 1, 1, "R4");
    endtask

    task automatic t_manchester;
        tx_bytes[0] = 8'hA5; tx_bytes[1] = 8'h00; tx_bytes[2] = 8'hFF;
        run_stream(2'd1, 1, 3, "R5");
    endtask

    task automatic t_biphase;
        tx_bytes[0] = 8'h00; tx_bytes[1] = 8'hFF; tx_bytes[2] = 8'h3C;
        tx_bytes[3] = 8'h81;
        run_stream(2'd2, 2, 4, "R6");
    endtask

    task automatic t_period;
        int cnt = 0;
        code_sel = 2'd0;
        bit_div  = 8'd3;
        enable   = 1'b1;
        write_byte(8'h6A);
        while (!busy) @(negedge clk);
        while (busy) begin
            cnt++;
            @(negedge clk);
        end
        check(cnt == 48 * 4, "R3", "busy cycles for one byte", cnt, 192);
    endtask

    task automatic t_code_freeze;
        tx_bytes[0] = 8'hC3;
        code_sel = 2'd1;
        bit_div  = 8'd0;
        enable   = 1'b1;
        fork
            write_byte(tx_bytes[0]);
            decode(2'd1, 1, 1, "R9");
            begin
                while (!busy) @(negedge clk);
                repeat (9) @(negedge clk);
                code_sel = 2'd0;
            end
        join
    endtask

    task automatic t_enable;
        code_sel = 2'd0;
        bit_div  = 8'd0;
        enable   = 1'b0;
        write_byte(8'h81);
        repeat (20) @(negedge clk);
        check(busy === 1'b0, "R10", "no start while disabled", int'(busy), 0);
        check(wr_ready === 1'b0, "R10", "stored byte waits", int'(wr_ready), 0);
        tx_bytes[0] = 8'h81;
        enable = 1'b1;
        decode(2'd0, 1, 1, "R10");
        // drop enable while a byte is in flight
        tx_bytes[0] = 8'h11;
        fork
            begin
                write_byte(8'h11);
                write_byte(8'h22);
            end
            begin
                while (!busy) @(negedge clk);
                repeat (5) @(negedge clk);
                enable = 1'b0;
            end
            decode(2'd0, 1, 1, "R10");
        join
        repeat (10) @(negedge clk);
        check(busy === 1'b0, "R10", "stopped after in-flight byte", int'(busy), 0);
        check(wr_ready === 1'b0, "R10", "second byte still stored", int'(wr_ready), 0);
        tx_bytes[0] = 8'h22;
        enable = 1'b1;
        decode(2'd0, 1, 1, "R10");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pwm();
        t_manchester();
        t_biphase();
        t_pwm_alt();
        t_period();
        t_code_freeze();
        t_enable();
        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule